// File: doc/BRIEF.md
# Watchdog Countdown Timer with Selectable Time Base

The block is a watchdog that counts down a programmed timeout and, when the count runs out, raises a short reset pulse for the keyboard-controller reset line and/or holds the power-good line low. Software programs it through a small byte-wide write port. There are three registers: a control byte, a low timeout byte and a high timeout byte. A free-running one-second tick from elsewhere on the chip is the only time reference.

The control byte holds three fields. One selects the time unit, so that each count is one second or one minute. The other two pick the expiry actions. The watchdog runs only while at least one action is selected, so writing zero to the control byte stops it. Writing the control byte loads the counter from the stored timeout. Writing the low timeout byte while the timer runs reloads the counter, and this write is the periodic kick. A build-time option narrows the counter to eight bits. In that build the high byte is dropped, and long periods are set in minute units. A sticky status flag records that an expiry took place.

Top module: `wdog_timer`

## Requirements
- R1: After reset, kbd_rst_o is 0, pwr_good_o is 1, expired_o is 0, all registers are 0 and the counter is stopped.
- R2: With control bits 6 and 5 both clear (for example, control written with 0x00), the timer does not count and no tick causes an expiry, even when the control write comes while a countdown is in progress.
- R3: Address 1 is the low timeout byte and address 2 is the high byte, forming a 16-bit timeout N. In seconds mode, the N-th tick after the counter is loaded causes the expiry.
- R4: Control bit 7 set selects seconds, so each tick is one count. Bit 7 clear selects minutes, so one count takes TICKS_PER_MIN ticks (60) and an expiry takes N*60 ticks.
- R5: With control bit 6 set, an expiry drives kbd_rst_o high for exactly PULSE_LEN (4) cycles, starting at the clock edge that takes in the final tick. With bit 6 clear, kbd_rst_o stays low.
- R6: With control bit 5 set, an expiry drives pwr_good_o low at that same edge, and it stays low until reset.
- R7: expired_o goes to 1 at the expiry edge and stays at 1 until reset, whatever is written afterwards.
- R8: A write to address 1 while the timer runs reloads the counter with the new full timeout and restarts the minute prescaler (the kick).
- R9: A timeout of zero keeps the counter stopped, so no expiry happens even with action bits set.
- R10: When NARROW=1 the counter is 8 bits wide and writes to address 2 are ignored, so the timeout is the low byte alone.
- R11: A write to address 0 loads the counter from the stored timeout and clears the prescaler. A write to address 2 alone does not load the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 timeout low, 2 timeout high |
| wr_data_i | input | 8 | Write data |
| tick_i | input | 1 | One-cycle pulse once per second |
| kbd_rst_o | output | 1 | Keyboard reset pulse on expiry |
| pwr_good_o | output | 1 | Power-good, forced low after an expiry when bit 5 is set |
| expired_o | output | 1 | Sticky expiry status |

## Verification
A write or tick is driven at a falling edge and takes effect at the next rising edge. Every output is a register, and the expiry decision is combinational from the counter, so the status flag and both reset outputs change in the same cycle as the final tick. The kbd_rst_o pulse then ends PULSE_LEN cycles later. The driver enqueues each expected value tagged with the absolute cycle it is due: offset 1 for the level outputs, and offsets 1, 3 and 4 to frame the pulse. The monitor samples 2 ns after each rising edge and flags any entry it reaches late as a miss. Tick counts one short of the timeout come before each expiry check, so an early expiry cannot pass unseen.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_TMO_LO = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_TMO_HI = 2'd2;
  localparam int CTRL_SECS = 7;
  localparam int CTRL_KBD  = 6;
  localparam int CTRL_PWR  = 5;

  typedef struct packed {
    logic secs;
    logic kbd_en;
    logic pwr_en;
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output wdog_ctrl_t        ctrl_o,
  output logic [CNT_W-1:0]  tmo_o,
  output logic              load_o
);
  wdog_ctrl_t ctrl_q;
  logic [7:0] lo_q, lo_sel;
  logic       wr_ctrl, wr_lo, running;

  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_lo   = wr_en_i && (wr_addr_i == ADDR_TMO_LO);
  assign running = ctrl_q.kbd_en | ctrl_q.pwr_en;
  assign lo_sel  = wr_lo ? wr_data_i : lo_q;
  assign load_o  = wr_ctrl | (wr_lo & running);
  assign ctrl_o  = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      lo_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= '{secs:   wr_data_i[CTRL_SECS],
                               kbd_en: wr_data_i[CTRL_KBD],
                               pwr_en: wr_data_i[CTRL_PWR]};
      if (wr_lo) lo_q <= wr_data_i;
    end
  end

  generate
    if (CNT_W > 8) begin : g_wide
      logic [CNT_W-9:0] hi_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hi_q <= '0;
        else if (wr_en_i && (wr_addr_i == ADDR_TMO_HI)) hi_q <= wr_data_i[CNT_W-9:0];
      end
      assign tmo_o = {hi_q, lo_sel};
    end else begin : g_narrow
      assign tmo_o = lo_sel[CNT_W-1:0];
    end
  endgenerate

  assert_unit_latch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (ctrl_o.secs == $past(wr_data_i[CTRL_SECS])));
  assert_hi_no_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_TMO_HI) |-> !load_o);
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int TICKS_PER_MIN = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic secs_i,
  input  logic clear_i,
  output logic step_o
);
  localparam int PRE_W = (TICKS_PER_MIN > 1) ? $clog2(TICKS_PER_MIN) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(TICKS_PER_MIN - 1);

  logic [PRE_W-1:0] pre_q;
  logic             adv;

  assign adv    = tick_i & run_i;
  assign step_o = adv & (secs_i | (pre_q == LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (clear_i)           pre_q <= '0;
    else if (adv && !secs_i)    pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end

  assert_pre_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= LAST);
  assert_pre_advance_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !secs_i && !clear_i && pre_q != LAST) |=> (pre_q == PRE_W'($past(pre_q) + 1'b1)));
  assert_pre_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (pre_q == '0));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] tmo_i,
  input  logic             step_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  // final count consumed; a simultaneous load wins
  assign expire_o = step_i && !load_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= tmo_i;
    else if (step_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assert_zero_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
  assert_no_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (cnt_q <= $past(cnt_q)));
  assert_reload_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(tmo_i)));
endmodule

// File: rtl/wdog_actions.sv
module wdog_actions #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic kbd_en_i,
  input  logic pwr_en_i,
  output logic kbd_rst_o,
  output logic pwr_good_o,
  output logic expired_o
);
  localparam int KBD_W = $clog2(PULSE_LEN + 1);

  logic [KBD_W-1:0] kbd_cnt_q;
  logic             pwr_bad_q, expired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kbd_cnt_q <= '0;
      pwr_bad_q <= 1'b0;
      expired_q <= 1'b0;
    end else begin
      if (expire_i && kbd_en_i)  kbd_cnt_q <= KBD_W'(PULSE_LEN);
      else if (kbd_cnt_q != '0)  kbd_cnt_q <= kbd_cnt_q - 1'b1;
      if (expire_i && pwr_en_i)  pwr_bad_q <= 1'b1;
      if (expire_i)              expired_q <= 1'b1;
    end
  end

  assign kbd_rst_o  = (kbd_cnt_q != '0);
  assign pwr_good_o = !pwr_bad_q;
  assign expired_o  = expired_q;

  assert_kbd_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && kbd_en_i) |=> kbd_rst_o);
  assert_kbd_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(kbd_rst_o) |-> $past(expire_i && kbd_en_i));
  assert_pwr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_o |=> !pwr_good_o);
  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o |=> expired_o);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter bit NARROW        = 1'b0,
  parameter int TICKS_PER_MIN = 60,
  parameter int PULSE_LEN     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              tick_i,
  output logic              kbd_rst_o,
  output logic              pwr_good_o,
  output logic              expired_o
);
  localparam int CNT_W = NARROW ? 8 : 16;

  wdog_ctrl_t       ctrl;
  logic [CNT_W-1:0] tmo;
  logic             load, step, expire, run;

  assign run = ctrl.kbd_en | ctrl.pwr_en;

  wdog_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ctrl_o(ctrl), .tmo_o(tmo), .load_o(load)
  );

  wdog_prescale #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_pre (
    .clk_i, .rst_ni, .tick_i, .run_i(run), .secs_i(ctrl.secs),
    .clear_i(load), .step_o(step)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .tmo_i(tmo), .step_i(step), .expire_o(expire)
  );

  wdog_actions #(.PULSE_LEN(PULSE_LEN)) u_act (
    .clk_i, .rst_ni, .expire_i(expire), .kbd_en_i(ctrl.kbd_en),
    .pwr_en_i(ctrl.pwr_en), .kbd_rst_o, .pwr_good_o, .expired_o
  );

  assert_idle_no_expire_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !expire);
endmodule

// File: tb/wdog_timer_tb_top.sv
module wdog_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick = 1'b0;
  logic       kbd_w, pg_w, ex_w, kbd_n, pg_n, ex_n;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct {
    int    due;
    int    which;
    logic  kbd;
    logic  pg;
    logic  ex;
    string tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .tick_i(tick),
    .kbd_rst_o(kbd_w), .pwr_good_o(pg_w), .expired_o(ex_w)
  );

  wdog_timer #(.NARROW(1'b1)) dut_n_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .tick_i(tick),
    .kbd_rst_o(kbd_n), .pwr_good_o(pg_n), .expired_o(ex_n)
  );

  // monitor: samples 2 ns after each rising edge
  always begin
    @(posedge clk);
    #2;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic a_k, a_p, a_e;
      it  = sb.pop_front();
      a_k = it.which ? kbd_n : kbd_w;
      a_p = it.which ? pg_n  : pg_w;
      a_e = it.which ? ex_n  : ex_w;
      n_chk++;
      if (it.due < cyc || a_k !== it.kbd || a_p !== it.pg || a_e !== it.ex) begin
        n_fail++;
        $display("FAIL %s dut%0d cyc %0d: kbd/pg/exp got %b%b%b exp %b%b%b (due %0d)",
                 it.tag, it.which, cyc, a_k, a_p, a_e, it.kbd, it.pg, it.ex, it.due);
      end
    end
  end

  task automatic expect_at(input int off, input int which, input logic k,
                           input logic p, input logic e, input string tag);
    item_t it;
    it.due = cyc + off; it.which = which; it.kbd = k; it.pg = p; it.ex = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic expect_both(input int off, input logic k, input logic p,
                             input logic e, input string tag);
    expect_at(off, 0, k, p, e, tag);
    expect_at(off, 1, k, p, e, tag);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic do_reset();
    drain();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_both(1, 1'b0, 1'b1, 1'b0, "R1 reset");
    drain();

    // R2 disabled timer ignores ticks
    wr(2'd1, 8'd3); wr(2'd2, 8'd0); wr(2'd0, 8'h00);
    ticks(10);
    expect_both(1, 1'b0, 1'b1, 1'b0, "R2 disabled");
    drain();

    // R3/R5 seconds expiry, 4-cycle kbd pulse
    wr(2'd0, 8'hC0);
    ticks(2);
    expect_both(1, 1'b0, 1'b1, 1'b0, "R3 before expiry");
    drain();
    ticks(1);
    expect_both(1, 1'b1, 1'b1, 1'b1, "R5 pulse start");
    expect_both(3, 1'b1, 1'b1, 1'b1, "R5 pulse held");
    expect_both(4, 1'b0, 1'b1, 1'b1, "R5 pulse end");
    drain();
    // R7 sticky after further writes and ticks
    wr(2'd0, 8'h00); ticks(3);
    expect_both(1, 1'b0, 1'b1, 1'b1, "R7 sticky");
    do_reset();
    expect_both(1, 1'b0, 1'b1, 1'b0, "R1 reset clears");

    // R3 16-bit timeout vs R10 narrow build
    wr(2'd1, 8'd4); wr(2'd2, 8'd1); wr(2'd0, 8'hC0);
    ticks(4);
    expect_at(1, 1, 1'b1, 1'b1, 1'b1, "R10 narrow ignores high byte");
    expect_at(1, 0, 1'b0, 1'b1, 1'b0, "R3 wide still counting");
    drain();
    ticks(255);
    expect_at(1, 0, 1'b0, 1'b1, 1'b0, "R3 wide at N-1");
    drain();
    ticks(1);
    expect_at(1, 0, 1'b1, 1'b1, 1'b1, "R3 wide expiry at 260");
    do_reset();

    // R6 power-good action only
    wr(2'd1, 8'd2); wr(2'd0, 8'hA0);
    ticks(2);
    expect_both(1, 1'b0, 1'b0, 1'b1, "R6 pwr low, R5 no kbd");
    drain();
    repeat (10) @(negedge clk);
    expect_both(1, 1'b0, 1'b0, 1'b1, "R6 pwr held");
    do_reset();
    expect_both(1, 1'b0, 1'b1, 1'b0, "R6 pwr restored by reset");
    drain();

    // R4 minute units
    wr(2'd1, 8'd2); wr(2'd0, 8'h40);
    ticks(119);
    expect_both(1, 1'b0, 1'b1, 1'b0, "R4 minutes at 119 ticks");
    drain();
    ticks(1);
    expect_both(1, 1'b1, 1'b1, 1'b1, "R4 minutes expiry at 120");
    do_reset();

    // R8 kick reloads
    wr(2'd1, 8'd3); wr(2'd0, 8'hC0);
    ticks(2);
    wr(2'd1, 8'd3);
    ticks(2);
    expect_both(1, 1'b0, 1'b1, 1'b0, "R8 kick delays expiry");
    drain();
    ticks(1);
    expect_both(1, 1'b1, 1'b1, 1'b1, "R8 expiry after kick");
    do_reset();

    // R8 kick restarts minute prescaler
    wr(2'd1, 8'd1); wr(2'd0, 8'h40);
    ticks(50);
    wr(2'd1, 8'd1);
    ticks(59);
    expect_both(1, 1'b0, 1'b1, 1'b0, "R8 prescaler restarted");
    drain();
    ticks(1);
    expect_both(1, 1'b1, 1'b1, 1'b1, "R8 minute after kick");
    do_reset();

    // R9 zero timeout stays stopped; R11 high write alone no load
    wr(2'd1, 8'd0); wr(2'd2, 8'd0); wr(2'd0, 8'hC0);
    wr(2'd2, 8'd0);
    ticks(5);
    expect_both(1, 1'b0, 1'b1, 1'b0, "R9 zero timeout");
    drain();

    // R11 control write loads stored timeout
    wr(2'd0, 8'h00); wr(2'd1, 8'd5); wr(2'd0, 8'hC0);
    ticks(4);
    expect_both(1, 1'b0, 1'b1, 1'b0, "R11 loaded at N-1");
    drain();
    ticks(1);
    expect_both(1, 1'b1, 1'b1, 1'b1, "R11 expiry after ctrl load");
    do_reset();

    // R2 disable mid-countdown
    wr(2'd1, 8'd2); wr(2'd0, 8'hC0);
    ticks(1);
    wr(2'd0, 8'h00);
    ticks(5);
    expect_both(1, 1'b0, 1'b1, 1'b0, "R2 disable mid-run");
    drain();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule